// File: doc/BRIEF.md
# Rotating Priority Resolver

This block decides whether an interrupt controller should raise a request toward the processor, and if so which of its eight lines wins. It takes the pending-request vector and the mask vector, and it holds two pieces of state. One is the in-service vector. The other is a three-bit rotation base that sets which line currently has the highest priority. Priority is counted as an offset from the base, and a smaller offset means higher priority. A candidate fires only when its offset is strictly smaller than the offset of the best line already in service. On the primary controller in special fully nested mode, the cascade line (line 2) is left out of the in-service comparison. This lets a secondary controller nest further requests behind it.

An acknowledge pulse accepts the current winner. In normal mode the winner's in-service bit is set. In automatic end-of-interrupt mode the bit is not set. If rotation on automatic end-of-interrupt is also enabled, the base moves to one past the acknowledged line. A load port lets the surrounding command logic write the in-service vector and the base directly. End-of-interrupt and explicit rotation commands are handled through that port, and decoding them lies outside this block.

Top module: `rot_prio_resolver`

## Requirements
- R1: After reset the in-service vector is 0, the base is 0, and with no pending request the valid output is 0.
- R2: Candidates are pend_i AND NOT mask_i. A masked or non-pending line never wins.
- R3: The offset of line l is (l - base) mod 8. The candidate with the smallest offset wins, and irq_line_o = (offset + base) mod 8.
- R4: irq_valid_o is 1 only when the winning offset is strictly smaller than the smallest offset among set in-service bits. With no in-service bit set, any candidate fires.
- R5: When sfnm_i and primary_i are both 1, in-service bit 2 is ignored in the in-service comparison. With either flag at 0, bit 2 counts like any other bit.
- R6: An ack_i with irq_valid_o high and aeoi_i low sets in-service bit irq_line_o at the next clock edge and leaves the base unchanged.
- R7: An ack_i with irq_valid_o high and aeoi_i high leaves the in-service vector unchanged. The base becomes (irq_line_o + 1) mod 8 if rot_aeoi_i is 1, and otherwise stays the same.
- R8: With ld_en_i low, an ack_i while irq_valid_o is low changes neither the in-service vector nor the base, and neither does any cycle without ack_i.
- R9: ld_en_i writes ld_isr_i and ld_base_i into the state at the next edge and takes precedence over a simultaneous ack_i.
- R10: irq_valid_o and irq_line_o are combinational from the inputs and the state, so valid falls in the same cycle that the winning request is masked or withdrawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | 8 | Pending request vector |
| mask_i | input | 8 | Mask vector, 1 blocks a line |
| sfnm_i | input | 1 | Special fully nested mode |
| primary_i | input | 1 | This is the primary controller |
| aeoi_i | input | 1 | Automatic end-of-interrupt mode |
| rot_aeoi_i | input | 1 | Rotate base on automatic end-of-interrupt |
| ack_i | input | 1 | Acknowledge the current winner |
| ld_en_i | input | 1 | Load in-service vector and base |
| ld_isr_i | input | 8 | In-service value to load |
| ld_base_i | input | 3 | Base value to load |
| irq_valid_o | output | 1 | A request should be raised |
| irq_line_o | output | 3 | Winning line number |
| isr_o | output | 8 | Current in-service vector |
| base_o | output | 3 | Current rotation base |

## Verification
The valid flag and the line number are due in the same cycle as any change on pend_i, mask_i or the mode flags. The bench therefore sweeps those inputs between clock edges and samples one time unit after each change, with no edge in between that could alter state. The in-service vector and the base change one edge after an acknowledge or a load. The bench drives those pulses at a falling edge, releases them at the next falling edge, and reads the state just after that, so exactly one rising edge has acted.

// File: rtl/rpr_pkg.sv
package rpr_pkg;

  // state update selected for the coming clock edge
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_AEOI = 2'd2,
    ACT_LOAD = 2'd3
  } rpr_act_e;

  // line number for a given offset from the base (power-of-two line count)
  function automatic int unsigned line_of(int unsigned off, int unsigned base, int unsigned n);
    return (off + base) % n;
  endfunction

endpackage

// File: rtl/rpr_search.sv
module rpr_search #(
  parameter int N  = 8,
  localparam int LW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  input  logic [LW-1:0] base_i,
  output logic [LW:0]   off_o
);
  logic [N-1:0] rot;

  // rot[p] is the line sitting p places after the base
  genvar p;
  generate
    for (p = 0; p < N; p++) begin : g_rot
      logic [LW-1:0] idx;
      assign idx    = LW'(p) + base_i;
      assign rot[p] = vec_i[idx];
    end
  endgenerate

  // smallest set offset, N when empty
  always_comb begin
    off_o = (LW+1)'(N);
    for (int k = N - 1; k >= 0; k--) begin
      if (rot[k]) off_o = (LW+1)'(k);
    end
  end
endmodule

// File: rtl/rpr_state.sv
module rpr_state
  import rpr_pkg::*;
#(
  parameter int N  = 8,
  localparam int LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rpr_act_e      act_i,
  input  logic [LW-1:0] line_i,
  input  logic          rot_i,
  input  logic [N-1:0]  ld_isr_i,
  input  logic [LW-1:0] ld_base_i,
  output logic [N-1:0]  isr_q,
  output logic [LW-1:0] base_q
);
  logic [N-1:0] line_bit;
  assign line_bit = N'(1) << line_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q  <= '0;
      base_q <= '0;
    end else begin
      case (act_i)
        ACT_LOAD: begin
          isr_q  <= ld_isr_i;
          base_q <= ld_base_i;
        end
        ACT_SET:  isr_q <= isr_q | line_bit;
        ACT_AEOI: if (rot_i) base_q <= line_i + LW'(1);
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/rot_prio_resolver.sv
module rot_prio_resolver
  import rpr_pkg::*;
#(
  parameter int N       = 8,
  parameter int CASCADE = 2,
  localparam int LW     = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  pend_i,
  input  logic [N-1:0]  mask_i,
  input  logic          sfnm_i,
  input  logic          primary_i,
  input  logic          aeoi_i,
  input  logic          rot_aeoi_i,
  input  logic          ack_i,
  input  logic          ld_en_i,
  input  logic [N-1:0]  ld_isr_i,
  input  logic [LW-1:0] ld_base_i,
  output logic          irq_valid_o,
  output logic [LW-1:0] irq_line_o,
  output logic [N-1:0]  isr_o,
  output logic [LW-1:0] base_o
);
  logic [N-1:0]  isr_q;
  logic [LW-1:0] base_q;
  logic [N-1:0]  cand_w;
  logic [N-1:0]  svc_w;
  logic [LW:0]   req_off_w;
  logic [LW:0]   svc_off_w;
  logic          fire_w;
  rpr_act_e      act_w;

  assign cand_w = pend_i & ~mask_i;

  // cascade line drops out of the in-service comparison when exempted
  always_comb begin
    svc_w = isr_q;
    if (sfnm_i && primary_i) svc_w[CASCADE] = 1'b0;
  end

  rpr_search #(.N(N)) u_req (.vec_i(cand_w), .base_i(base_q), .off_o(req_off_w));
  rpr_search #(.N(N)) u_svc (.vec_i(svc_w),  .base_i(base_q), .off_o(svc_off_w));

  assign fire_w      = (req_off_w < svc_off_w);
  assign irq_valid_o = fire_w;
  assign irq_line_o  = LW'(line_of(32'(req_off_w[LW-1:0]), 32'(base_q), N));

  always_comb begin
    if (ld_en_i)               act_w = ACT_LOAD;
    else if (ack_i && fire_w)  act_w = aeoi_i ? ACT_AEOI : ACT_SET;
    else                       act_w = ACT_NONE;
  end

  rpr_state #(.N(N)) u_state (
    .clk(clk), .rst_n(rst_n), .act_i(act_w), .line_i(irq_line_o),
    .rot_i(rot_aeoi_i), .ld_isr_i(ld_isr_i), .ld_base_i(ld_base_i),
    .isr_q(isr_q), .base_q(base_q)
  );

  assign isr_o  = isr_q;
  assign base_o = base_q;
endmodule

// File: rtl/rpr_checker.sv
module rpr_checker #(
  parameter int N = 8,
  localparam int LW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  pend_i,
  input logic [N-1:0]  mask_i,
  input logic          aeoi_i,
  input logic          rot_aeoi_i,
  input logic          ack_i,
  input logic          ld_en_i,
  input logic [N-1:0]  ld_isr_i,
  input logic [LW-1:0] ld_base_i,
  input logic          irq_valid_o,
  input logic [LW-1:0] irq_line_o,
  input logic [N-1:0]  isr_o,
  input logic [LW-1:0] base_o
);
  // R2: a winner is pending and unmasked
  a_r2_winner_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> (pend_i[irq_line_o] && !mask_i[irq_line_o]));

  // R4: a line already in service never fires again
  a_r4_not_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && irq_line_o != LW'(2)) |-> !isr_o[irq_line_o]);

  a_r6_set_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_valid_o && !aeoi_i && !ld_en_i) |=>
      (isr_o == ($past(isr_o) | (N'(1) << $past(irq_line_o)))) && (base_o == $past(base_o)));

  a_r7_aeoi_isr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_valid_o && aeoi_i && !ld_en_i) |=> (isr_o == $past(isr_o)));

  a_r7_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_valid_o && aeoi_i && rot_aeoi_i && !ld_en_i) |=>
      (base_o == LW'($past(irq_line_o) + LW'(1))));

  a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en_i && !(ack_i && irq_valid_o)) |=> ($stable(isr_o) && $stable(base_o)));

  a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en_i |=> (isr_o == $past(ld_isr_i)) && (base_o == $past(ld_base_i)));
endmodule

bind rot_prio_resolver rpr_checker #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .mask_i(mask_i),
  .aeoi_i(aeoi_i), .rot_aeoi_i(rot_aeoi_i), .ack_i(ack_i),
  .ld_en_i(ld_en_i), .ld_isr_i(ld_isr_i), .ld_base_i(ld_base_i),
  .irq_valid_o(irq_valid_o), .irq_line_o(irq_line_o),
  .isr_o(isr_o), .base_o(base_o)
);

// File: tb/sim_rot_prio_resolver.sv
module sim_rot_prio_resolver;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] pend = '0, mask = '0, ld_isr = '0;
  logic sfnm = 0, prim = 0, aeoi = 0, rot = 0, ack = 0, ld_en = 0;
  logic [2:0] ld_base = '0;
  logic valid;
  logic [2:0] line, base;
  logic [7:0] isr;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  rot_prio_resolver u0 (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .mask_i(mask), .sfnm_i(sfnm),
    .primary_i(prim), .aeoi_i(aeoi), .rot_aeoi_i(rot), .ack_i(ack),
    .ld_en_i(ld_en), .ld_isr_i(ld_isr), .ld_base_i(ld_base),
    .irq_valid_o(valid), .irq_line_o(line), .isr_o(isr), .base_o(base)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // rank of a line measured from the base; 8 when the vector is empty
  function automatic int best_rank(logic [7:0] v, int b);
    int r = 8;
    for (int l = 0; l < 8; l++)
      if (v[l] && ((l - b + 8) % 8) < r) r = (l - b + 8) % 8;
    return r;
  endfunction

  task automatic load(logic [7:0] i, logic [2:0] b);
    @(negedge clk); ld_en = 1; ld_isr = i; ld_base = b;
    @(negedge clk); ld_en = 0;
    #1;
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
    #1;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] isr_set [6] = '{8'h00, 8'h04, 8'h81, 8'h10, 8'hFF, 8'h22};
    #(PERIOD*2 + 2);
    // R1 reset state
    check("R1 isr", isr, 0); check("R1 base", base, 0); check("R1 valid", valid, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 R3 R4 R5 sweep
    for (int b = 0; b < 8; b++) begin
      for (int s = 0; s < 6; s++) begin
        load(isr_set[s], 3'(b));
        for (int m = 0; m < 4; m++) begin
          sfnm = m[0]; prim = m[1];
          for (int p = 0; p < 256; p++) begin
            logic [7:0] cv, sv;
            int cr, sr;
            pend = 8'(p);
            mask = 8'((p * 29 + b * 3 + s) & 8'h5A);
            #1;
            cv = pend & ~mask;
            sv = isr_set[s];
            if (sfnm && prim) sv[2] = 1'b0;
            cr = best_rank(cv, b);
            sr = best_rank(sv, b);
            check("R4 R5 valid", valid, (cr < sr) ? 1 : 0);
            if (cr < sr) check("R2 R3 line", line, (cr + b) % 8);
          end
        end
      end
    end
    sfnm = 0; prim = 0; mask = 0;

    // R5 named case
    load(8'h04, 3'd0); pend = 8'h08; #1;
    check("R5 bit2 counts", valid, 0);
    sfnm = 1; #1; check("R5 sfnm secondary", valid, 0);
    prim = 1; #1; check("R5 exempt valid", valid, 1); check("R5 exempt line", line, 3);
    sfnm = 0; prim = 0;

    // R6 ack sets in-service bit
    load(8'h00, 3'd5); pend = 8'h81; #1;
    check("R3 line base5", line, 7);
    pulse_ack();
    check("R6 isr", isr, 8'h80); check("R6 base", base, 5);
    check("R4 blocked", valid, 0);
    // R8 ack without valid
    pulse_ack();
    check("R8 isr", isr, 8'h80); check("R8 base", base, 5);

    // R7 aeoi with rotation
    load(8'h00, 3'd0); pend = 8'h10; aeoi = 1; rot = 1; #1;
    pulse_ack();
    check("R7 isr held", isr, 0); check("R7 rotate", base, 5);
    // R7 aeoi without rotation: line 4 now offset 7 from base 5
    rot = 0; #1; check("R7 valid", valid, 1); check("R7 line", line, 4);
    pulse_ack();
    check("R7 no rotate base", base, 5); check("R7 no rotate isr", isr, 0);
    aeoi = 0;

    // R9 load wins over ack
    pend = 8'h01; #1;
    @(negedge clk); ack = 1; ld_en = 1; ld_isr = 8'h40; ld_base = 3'd2;
    @(negedge clk); ack = 0; ld_en = 0; #1;
    check("R9 isr", isr, 8'h40); check("R9 base", base, 2);

    // R10 same-cycle fall on mask
    load(8'h00, 3'd0); pend = 8'h08; #1;
    check("R10 valid up", valid, 1);
    mask = 8'h08; #1; check("R10 masked fall", valid, 0);
    mask = 0; pend = 0; #1; check("R10 withdrawn", valid, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule